// File: doc/BRIEF.md
# 8-bit Timer with Overflow Output

An 8-bit up-counter whose count source is chosen by a 3-bit clock-select field. The field can stop the counter, run it on every system clock, run it on one of four prescaled rates, or run it on rising or falling edges of an external pin. The prescaler is a free-running divider that starts from zero at reset. The external pin passes through a synchronizer and then an edge-detect state machine. That machine has two states, `EXT_LOW` and `EXT_HIGH`. The `rise` transition moves it from EXT_LOW to EXT_HIGH when the synchronized pin reads 1. The `fall` transition moves it from EXT_HIGH to EXT_LOW when the synchronized pin reads 0. Each transition emits a one-cycle event pulse.

When the counter wraps from its all-ones value to zero, it sets a sticky overflow flag. The flag drives an interrupt request when the overflow interrupt enable is set. The same wrap also applies an action to an output pin, chosen by a 2-bit mode field. Software can apply that pin action without a wrap by writing the force strobe in the control register. The force strobe leaves the counter and the flag alone.

Software reaches the block through three write ports: one for the count, one for the control byte and one for the flag. Read values are always visible on output ports. An interrupt controller acknowledges a serviced overflow through a single acknowledge input.

Top module: `tmr8_ovf_timer`

## Requirements
- R1: After reset the count, the control readback, the flag, the interrupt request and the output pin are all 0, and the external-edge state machine is in EXT_LOW.
- R2: With clock-select 000 the count holds its value on every clock.
- R3: With clock-select 001 the count rises by one on every clock edge.
- R4: Clock-select 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. The prescaler phase equals the number of clock edges since reset. The count advances on an edge where that phase modulo the divisor is the divisor minus one.
- R5: With clock-select 111 the count advances on rising pin transitions only; with 110, on falling transitions only. In each case the count changes on the third rising clock edge after the pin changes.
- R6: A count write loads the written value at that edge and takes priority over counting. Counting resumes on the next edge.
- R7: A count step from 255 to 0 sets the overflow flag, and the flag stays set until cleared.
- R8: Two things clear the flag: an acknowledge, or a flag write with data 1. A flag write with data 0 leaves the flag unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R9: The interrupt request is 1 exactly when the flag is 1 and enable bit 6 of the control byte is 1.
- R10: On a wrap, the output pin follows control bits [4:3]: 00 leaves it unchanged, 01 inverts it, 10 drives it to 0, 11 drives it to 1.
- R11: A control write with bit 5 set applies the pin action of the mode already stored before that write. It leaves the count and the flag unchanged, and bit 5 reads back as 0.
- R12: The control readback is {bit 6 enable, bit 5 zero, bits [4:3] mode, bits [2:0] clock-select}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write value |
| cnt_q | output | 8 | Current count |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 7 | Control write value |
| ctl_q | output | 7 | Control readback |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write value, 1 clears |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ext_pin | input | 1 | External count source |
| flag_q | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| ovf_pin | output | 1 | Overflow output pin |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 10-bit prescaler and a two-stage synchronizer. The 8-bit width lets a preloaded count reach its wrap within two edges, so the wrap, flag and pin paths stay short. The bench checks the divide-by-8 and divide-by-64 paths against the free-running prescaler phase, which it tracks from reset. The two-stage synchronizer fixes the external-edge latency at three clock edges, and the bench samples exactly there.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_CLK      = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } csel_e;

    typedef enum logic [1:0] {
        OM_NONE   = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_CLEAR  = 2'd2,
        OM_SET    = 2'd3
    } omode_e;

    localparam int CTL_W      = 7;
    localparam int CTL_CS_LSB = 0;
    localparam int CTL_OM_LSB = 3;
    localparam int CTL_FORCE  = 5;
    localparam int CTL_IE     = 6;
    localparam int NUM_TAPS   = 4;

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [tmr8_pkg::NUM_TAPS-1:0] taps
);
    localparam int TAP_BITS [tmr8_pkg::NUM_TAPS] = '{3, 6, 8, 10};

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar g = 0; g < tmr8_pkg::NUM_TAPS; g++) begin : g_tap
        assign taps[g] = &pre_q[TAP_BITS[g]-1:0];
    end

    // A slower tap may only fire together with every faster tap.
    AST_TAP_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        taps[3] |-> (taps[2] && taps[1] && taps[0])); // R4

endmodule

// File: rtl/tmr8_ext_edge.sv
module tmr8_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef enum logic {EXT_LOW = 1'b0, EXT_HIGH = 1'b1} ext_state_e;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    ext_state_e             state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXT_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_LOW:  if (synced)  state_d = EXT_HIGH;
            EXT_HIGH: if (!synced) state_d = EXT_LOW;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            EXT_LOW:  rise = synced;
            EXT_HIGH: fall = !synced;
        endcase
    end

    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5
    AST_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R5

endmodule

// File: rtl/tmr8_ovf_timer.sv
module tmr8_ovf_timer #(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cnt_wr,
    input  logic [CNT_W-1:0]           cnt_wdata,
    output logic [CNT_W-1:0]           cnt_q,
    input  logic                       ctl_wr,
    input  logic [tmr8_pkg::CTL_W-1:0] ctl_wdata,
    output logic [tmr8_pkg::CTL_W-1:0] ctl_q,
    input  logic                       flag_wr,
    input  logic                       flag_wdata,
    input  logic                       irq_ack,
    input  logic                       ext_pin,
    output logic                       flag_q,
    output logic                       irq,
    output logic                       ovf_pin
);
    import tmr8_pkg::*;

    logic [NUM_TAPS-1:0] taps;
    logic                ext_rise, ext_fall;
    csel_e               csel_q;
    omode_e              omode_q;
    logic                ie_q;
    logic                tick, wrap, force_hit;

    tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps)
    );

    tmr8_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // Count source selection
    always_comb begin
        tick = 1'b0;
        unique case (csel_q)
            CS_STOP:     tick = 1'b0;
            CS_CLK:      tick = 1'b1;
            CS_DIV8:     tick = taps[0];
            CS_DIV64:    tick = taps[1];
            CS_DIV256:   tick = taps[2];
            CS_DIV1024:  tick = taps[3];
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
        endcase
    end

    assign wrap      = tick && !cnt_wr && (cnt_q == {CNT_W{1'b1}});
    assign force_hit = ctl_wr && ctl_wdata[CTL_FORCE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= cnt_wdata;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csel_q  <= CS_STOP;
            omode_q <= OM_NONE;
            ie_q    <= 1'b0;
        end else if (ctl_wr) begin
            csel_q  <= csel_e'(ctl_wdata[CTL_CS_LSB +: 3]);
            omode_q <= omode_e'(ctl_wdata[CTL_OM_LSB +: 2]);
            ie_q    <= ctl_wdata[CTL_IE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 flag_q <= 1'b0;
        else if (wrap)                              flag_q <= 1'b1;
        else if (irq_ack || (flag_wr && flag_wdata)) flag_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_pin <= 1'b0;
        end else if (wrap || force_hit) begin
            unique case (omode_q)
                OM_NONE:   ovf_pin <= ovf_pin;
                OM_TOGGLE: ovf_pin <= !ovf_pin;
                OM_CLEAR:  ovf_pin <= 1'b0;
                OM_SET:    ovf_pin <= 1'b1;
            endcase
        end
    end

    assign irq   = flag_q && ie_q;
    assign ctl_q = {ie_q, 1'b0, omode_q, csel_q};

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(cnt_wdata))); // R6
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (csel_q == CS_STOP && !cnt_wr) |=> $stable(cnt_q)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == {CNT_W{1'b1}}) |=> flag_q); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(tick && !cnt_wr && cnt_q == {CNT_W{1'b1}})) |=> !flag_q); // R8
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !force_hit) |=> $stable(ovf_pin)); // R10
    AST_FORCE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hit && !cnt_wr && !tick) |=> $stable(cnt_q)); // R11

endmodule

// File: tb/sim_tmr8_ovf_timer.sv
`timescale 1ns/1ps
module sim_tmr8_ovf_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_q;
    logic       ctl_wr = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic [6:0] ctl_q;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       irq_ack = 1'b0;
    logic       ext_pin = 1'b0;
    logic       flag_q, irq, ovf_pin;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    tmr8_ovf_timer u0 (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .irq_ack(irq_ack),
        .ext_pin(ext_pin), .flag_q(flag_q), .irq(irq), .ovf_pin(ovf_pin)
    );

    // {mode[1:0], expected pin after a forced action}, applied in order from pin = 0
    localparam logic [2:0] PIN_VEC [8] = '{
        3'b11_1, 3'b01_0, 3'b01_1, 3'b00_1, 3'b10_0, 3'b00_0, 3'b11_1, 3'b10_0
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic wr_ctl(input logic [6:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        flag_wr = 1'b1; flag_wdata = v;
        @(negedge clk);
        flag_wr = 1'b0;
    endtask

    function automatic int ticks(input int start, input int n, input int d);
        int t = 0;
        for (int k = 0; k < n; k++)
            if (((start + k) % d) == d - 1) t++;
        return t;
    endfunction

    initial begin
        int cw;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk("R1 count", cnt_q, 0);
        chk("R1 control", ctl_q, 0);
        chk("R1 flag", flag_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pin", ovf_pin, 0);

        // R10 R11 table of forced pin actions with the counter stopped
        for (int i = 0; i < 8; i++) begin
            wr_ctl({1'b0, 1'b0, PIN_VEC[i][2:1], 3'b000});
            wr_ctl({1'b0, 1'b1, PIN_VEC[i][2:1], 3'b000});
            chk("R11 force pin action", ovf_pin, PIN_VEC[i][0]);
            chk("R11 force keeps count", cnt_q, 0);
            chk("R11 force keeps flag", flag_q, 0);
            chk("R11 force reads zero", ctl_q[5], 0);
        end

        // R3 R6 system clock counting and load
        wr_ctl(7'h01);
        wr_cnt(8'h10);
        chk("R6 load value", cnt_q, 8'h10);
        step(5);
        chk("R3 count per clock", cnt_q, 8'h15);

        // R2 stop holds
        wr_ctl(7'h00);
        cw = cnt_q;
        step(20);
        chk("R2 stopped", cnt_q, cw);

        // R4 divide by 8 and 64
        wr_ctl(7'h02);
        wr_cnt(8'h00);
        cw = cyc;
        step(40);
        chk("R4 divide 8", cnt_q, ticks(cw, 40, 8));
        wr_ctl(7'h03);
        wr_cnt(8'h00);
        cw = cyc;
        step(200);
        chk("R4 divide 64", cnt_q, ticks(cw, 200, 64));

        // R5 external rising
        wr_ctl(7'h07);
        wr_cnt(8'h00);
        ext_pin = 1'b1;
        step(2);
        chk("R5 rise latency before", cnt_q, 0);
        step(1);
        chk("R5 rise counted", cnt_q, 1);
        ext_pin = 1'b0;
        step(5);
        chk("R5 rise mode ignores fall", cnt_q, 1);
        // R5 external falling
        wr_ctl(7'h06);
        ext_pin = 1'b1;
        step(5);
        chk("R5 fall mode ignores rise", cnt_q, 1);
        ext_pin = 1'b0;
        step(2);
        chk("R5 fall latency before", cnt_q, 1);
        step(1);
        chk("R5 fall counted", cnt_q, 2);

        // R7 R9 R10 wrap with toggle mode, enable off
        wr_ctl(7'h09);
        wr_cnt(8'hFE);
        step(1);
        chk("R7 no flag before wrap", flag_q, 0);
        step(1);
        chk("R7 wrap count", cnt_q, 0);
        chk("R7 flag set", flag_q, 1);
        chk("R10 toggle on wrap", ovf_pin, 1);
        chk("R9 irq masked", irq, 0);
        wr_ctl(7'h48);
        chk("R12 control readback", ctl_q, 7'h48);
        chk("R9 irq enabled", irq, 1);

        // R8 clearing rules
        wr_flag(1'b0);
        chk("R8 write zero no effect", flag_q, 1);
        wr_flag(1'b1);
        chk("R8 write one clears", flag_q, 0);
        chk("R9 irq follows flag", irq, 0);
        wr_ctl(7'h49);
        wr_cnt(8'hFF);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        chk("R8 wrap wins over ack", flag_q, 1);
        chk("R10 toggle second wrap", ovf_pin, 0);
        wr_ctl(7'h48);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        chk("R8 ack clears", flag_q, 0);
        chk("R9 irq after ack", irq, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule